// File: doc/BRIEF.md
# PHY Management Access Register

This block gives a host one 32-bit register through which it reaches the management registers of an external PHY over a two-wire serial management link (MDC clock, bidirectional MDIO data). The host writes a command word holding a direction bit, a register address and, for writes, sixteen data bits. The block then runs one clause-22 management frame on MDC/MDIO and reports completion through the top bit of the same register.

The meaning of the completion bit depends on the direction. For a PHY write it reads 1 while the frame runs and drops to 0 when the frame has finished. For a PHY read it reads 0 while the frame runs and rises to 1 once the returned data sits in the low sixteen bits. Software polls that bit. A full frame takes a fixed 128·DIV_HALF system clocks, far inside a polling budget of many milliseconds. The PHY address is a build-time parameter. Commands that arrive while a frame is running are dropped.

Top module: `pmr_mdio_reg`

## Requirements
- R1: After reset the register reads 0x0000_0000, MDC is low and the MDIO output enable is low.
- R2: The register answers only at host address OFFSET (default 0x60). A write to any other address changes nothing, and a read of any other address returns 0.
- R3: A command word with bit 31 = 1 starts a PHY write. Bit 31 reads 1 while that frame runs and 0 after it completes, and bits 15:0 keep the written data.
- R4: A command word with bit 31 = 0 starts a PHY read. Bit 31 reads 0 while that frame runs. At completion bit 31 reads 1 and bits 15:0 hold the 16 bits returned by the PHY.
- R5: Bits 23:16 of the command hold an 8-bit register address that reads back unchanged, and only its low five bits go into the frame. Bits 30:24 always read 0.
- R6: The frame sends 32 ones, start 01, then opcode 01 for a write or 10 for a read. It continues with the 5-bit PHY_ADDR and the 5-bit register address, MSB first. A write then drives turnaround 10 and the 16 data bits MSB first.
- R7: MDC is low when idle. It starts low on the clock edge that accepts a command, toggles every DIV_HALF system clocks, and completes 64 cycles. The command completes on the edge 128·DIV_HALF clocks after acceptance.
- R8: For a read, the MDIO output enable is low from turnaround (frame bit 46) on. The 16 data bits are taken from MDIO input on the MDC rising edges of frame bits 48..63, MSB first.
- R9: A register write that arrives while a frame is running is ignored. The register contents and the frame in flight are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | AW | Host register address for reads and writes |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write data (command word) |
| host_rdata | output | 32 | Register contents when host_addr equals OFFSET, else 0 |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO data driven by the block |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO data seen on the line |

## Verification
A behavioural PHY on MDC/MDIO decodes every frame and holds its own register file, and a clock-by-clock model predicts the register word, MDC and the output enable. The commands cover writes of mixed, all-zero and all-one data, and reads of registers the bench wrote and of registers it did not. This separates the two opposite completion-bit meanings and shows whether read data lands with the correct bit order. An address with the upper bits and the reserved bits set shows whether the truncation to five bits and the zero reserved field behave as specified. A write to a different host address, and a second command issued in the middle of a read frame, show that neither leaks into the register or onto the wire.

// File: rtl/pmr_pkg.sv
package pmr_pkg;

    localparam int FRAME_LEN  = 64;
    localparam int PRE_LEN    = 32;
    localparam int TA_BIT     = 46;
    localparam int DATA_BIT   = 48;
    localparam int DATA_W     = 16;
    localparam int REG_AW     = 5;
    localparam int PHY_AW     = 5;
    localparam int CMD_AW     = 8;
    localparam int BIT_W      = $clog2(FRAME_LEN);

    localparam logic [1:0] ST_CODE  = 2'b01;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] TA_WRITE = 2'b10;

    typedef struct packed {
        logic              flag;
        logic [CMD_AW-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              rd;
    } cmd_state_t;

    typedef struct packed {
        logic                 busy;
        logic [BIT_W-1:0]     bitn;
        logic [FRAME_LEN-1:0] shift;
        logic                 rd;
        logic [DATA_W-1:0]    rdata;
    } eng_state_t;

endpackage

// File: rtl/pmr_mdc_gen.sv
module pmr_mdc_gen #(
    parameter int DIV_HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } gen_state_t;

    gen_state_t st_d, st_q;
    logic       wrap;

    always_comb begin
        st_d = st_q;
        wrap = (st_q.cnt == LAST);
        if (!run) begin
            st_d.cnt = '0;
            st_d.mdc = 1'b0;
        end else if (wrap) begin
            st_d.cnt = '0;
            st_d.mdc = ~st_q.mdc;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mdc       = st_q.mdc;
    assign rise_tick = run & wrap & ~st_q.mdc;
    assign fall_tick = run & wrap &  st_q.mdc;

endmodule

// File: rtl/pmr_frame_engine.sv
module pmr_frame_engine
    import pmr_pkg::*;
#(
    parameter logic [PHY_AW-1:0] PHY_ADDR = 5'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_read,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              mdio_i,
    output logic              busy,
    output logic              done,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(FRAME_LEN - 1);
    localparam logic [BIT_W-1:0] TA_IDX    = BIT_W'(TA_BIT);
    localparam logic [BIT_W-1:0] DATA_IDX  = BIT_W'(DATA_BIT);

    eng_state_t           st_d, st_q;
    logic [FRAME_LEN-1:0] frame;

    // Frame image, MSB leaves first.
    always_comb begin
        frame = { {PRE_LEN{1'b1}},
                  ST_CODE,
                  (op_read ? OP_READ : OP_WRITE),
                  PHY_ADDR,
                  reg_addr,
                  (op_read ? 2'b11 : TA_WRITE),
                  (op_read ? {DATA_W{1'b1}} : wdata) };
    end

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy  = 1'b1;
                st_d.bitn  = '0;
                st_d.shift = frame;
                st_d.rd    = op_read;
                st_d.rdata = '0;
            end
        end else begin
            if (rise_tick && st_q.rd && (st_q.bitn >= DATA_IDX)) begin
                st_d.rdata = {st_q.rdata[DATA_W-2:0], mdio_i};
            end
            if (fall_tick) begin
                if (st_q.bitn == LAST_BIT) begin
                    st_d.busy  = 1'b0;
                    st_d.shift = '1;
                    done       = 1'b1;
                end else begin
                    st_d.bitn  = st_q.bitn + 1'b1;
                    st_d.shift = {st_q.shift[FRAME_LEN-2:0], 1'b1};
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.shift <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy    = st_q.busy;
    assign mdio_o  = st_q.shift[FRAME_LEN-1];
    assign mdio_oe = st_q.busy & (~st_q.rd | (st_q.bitn < TA_IDX));
    assign rdata   = st_q.rdata;

endmodule

// File: rtl/pmr_mdio_reg.sv
module pmr_mdio_reg
    import pmr_pkg::*;
#(
    parameter int                AW       = 8,
    parameter logic [AW-1:0]     OFFSET   = 8'h60,
    parameter int                DIV_HALF = 4,
    parameter logic [PHY_AW-1:0] PHY_ADDR = 5'd1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] host_addr,
    input  logic          host_wr,
    input  logic [31:0]   host_wdata,
    output logic [31:0]   host_rdata,
    output logic          mdc,
    output logic          mdio_o,
    output logic          mdio_oe,
    input  logic          mdio_i
);
    cmd_state_t        cmd_d, cmd_q;
    logic              sel, accept;
    logic              eng_busy, eng_done;
    logic              rise_tick, fall_tick;
    logic [DATA_W-1:0] eng_rdata;
    logic [31:0]       reg_word;
    logic              op_read_q;
    logic              unused_wbits;

    assign unused_wbits = ^host_wdata[30:24];

    assign sel    = (host_addr == OFFSET);
    assign accept = host_wr & sel & ~eng_busy;

    always_comb begin
        cmd_d = cmd_q;
        if (accept) begin
            cmd_d.flag = host_wdata[31];
            cmd_d.addr = host_wdata[23:16];
            cmd_d.data = host_wdata[15:0];
            cmd_d.rd   = ~host_wdata[31];
        end else if (eng_done) begin
            if (cmd_q.rd) begin
                cmd_d.flag = 1'b1;
                cmd_d.data = eng_rdata;
            end else begin
                cmd_d.flag = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cmd_q <= '0;
        else        cmd_q <= cmd_d;
    end

    assign reg_word   = {cmd_q.flag, 7'd0, cmd_q.addr, cmd_q.data};
    assign op_read_q  = cmd_q.rd;
    assign host_rdata = sel ? reg_word : 32'd0;

    pmr_mdc_gen #(.DIV_HALF(DIV_HALF)) u_mdc (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (eng_busy),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    pmr_frame_engine #(.PHY_ADDR(PHY_ADDR)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .op_read   (~host_wdata[31]),
        .reg_addr  (host_wdata[16 +: REG_AW]),
        .wdata     (host_wdata[15:0]),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_i    (mdio_i),
        .busy      (eng_busy),
        .done      (eng_done),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .rdata     (eng_rdata)
    );

endmodule

// File: rtl/pmr_checker.sv
module pmr_checker #(
    parameter int            AW     = 8,
    parameter logic [AW-1:0] OFFSET = 8'h60
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] host_addr,
    input logic          host_wr,
    input logic [31:0]   host_wdata,
    input logic          busy,
    input logic          mdc,
    input logic [31:0]   reg_word,
    input logic          op_read
);
    logic acc;
    assign acc = host_wr && (host_addr == OFFSET) && !busy;

    assert_idle_mdc_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    assert_write_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && host_wdata[31]) |=> reg_word[31]);

    assert_write_done_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !op_read) |-> !reg_word[31]);

    assert_flag_hold_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(reg_word[31]));

    assert_read_flag_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !host_wdata[31]) |=> !reg_word[31]);

    assert_read_done_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && op_read) |-> reg_word[31]);

    assert_other_offset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && host_wr && host_addr != OFFSET) |=> $stable(reg_word));

    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && host_wr) |=> (!busy || $stable(reg_word)));

endmodule

bind pmr_mdio_reg pmr_checker #(.AW(AW), .OFFSET(OFFSET)) u_pmr_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_addr  (host_addr),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .busy       (eng_busy),
    .mdc        (mdc),
    .reg_word   (reg_word),
    .op_read    (op_read_q)
);

// File: tb/tb_pmr_mdio_reg.sv
`timescale 1ns/1ps
module tb_pmr_mdio_reg;
    localparam int          H     = 4;
    localparam logic [4:0]  PHYA  = 5'd1;
    localparam logic [7:0]  OFS   = 8'h60;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  host_addr = OFS;
    logic        host_wr = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    pmr_mdio_reg #(.AW(8), .OFFSET(OFS), .DIV_HALF(H), .PHY_ADDR(PHYA)) dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, got, exp, $time);
        end
    endtask

    // Bench-side PHY register file
    logic [15:0] phy_mem [32];

    // Reference model
    bit          m_busy = 0;
    bit          m_read = 0;
    int          m_j = 0;
    logic        m_flag = 0;
    logic [7:0]  m_addr = 0;
    logic [15:0] m_data = 0;
    logic [1:0]  exp_op = 0;
    logic [4:0]  exp_reg = 0;
    logic [15:0] exp_wd = 0;

    always @(posedge clk) begin
        bit was_busy;
        cycles++;
        if (!rst_n) begin
            m_busy = 0; m_read = 0; m_j = 0;
            m_flag = 0; m_addr = 0; m_data = 0;
        end else begin
            was_busy = m_busy;
            if (was_busy) begin
                m_j++;
                if (m_j == 128 * H) begin
                    m_busy = 0;
                    if (m_read) begin
                        m_flag = 1;
                        m_data = phy_mem[m_addr[4:0]];
                    end else begin
                        m_flag = 0;
                    end
                end
            end else if (host_wr && host_addr == OFS) begin
                m_busy = 1; m_j = 0;
                m_flag = host_wdata[31];
                m_read = !host_wdata[31];
                m_addr = host_wdata[23:16];
                m_data = host_wdata[15:0];
                exp_op  = host_wdata[31] ? 2'b01 : 2'b10;
                exp_reg = host_wdata[20:16];
                exp_wd  = host_wdata[15:0];
            end
        end
    end

    // Per-clock comparison against the model
    always @(negedge clk) begin
        logic [31:0] e_rd;
        logic        e_mdc, e_oe;
        if (rst_n) begin
            e_rd  = (host_addr == OFS) ? {m_flag, 7'd0, m_addr, m_data} : 32'd0;
            e_mdc = m_busy && (((m_j / H) % 2) == 1);
            e_oe  = m_busy && (!m_read || ((m_j / (2 * H)) < 46));
            check(m_read ? "R4 register word" : "R3 register word", host_rdata, e_rd);
            check("R7 mdc", {31'd0, mdc}, {31'd0, e_mdc});
            check(m_read ? "R8 output enable" : "R6 output enable", {31'd0, mdio_oe}, {31'd0, e_oe});
        end
    end

    // Behavioural PHY responder and frame decoder
    int          ph_rises = 0;
    logic [63:0] cap = '0;
    logic [1:0]  ph_op = 0;
    logic [4:0]  ph_reg = 0;

    always @(posedge mdc) begin
        cap = {cap[62:0], (mdio_oe ? mdio_o : mdio_i)};
        ph_rises++;
        if (ph_rises == 36) ph_op = cap[1:0];
        if (ph_rises == 46) ph_reg = cap[4:0];
        if (ph_rises == 64) begin
            ph_rises = 0;
            check("R6 preamble", cap[63:32], 32'hFFFF_FFFF);
            check("R6 start", {30'd0, cap[31:30]}, 32'd1);
            check("R6 opcode", {30'd0, cap[29:28]}, {30'd0, exp_op});
            check("R6 phy address", {27'd0, cap[27:23]}, {27'd0, PHYA});
            check("R5 register address", {27'd0, cap[22:18]}, {27'd0, exp_reg});
            if (cap[29:28] == 2'b01) begin
                check("R6 turnaround", {30'd0, cap[17:16]}, 32'd2);
                check("R6 write data", {16'd0, cap[15:0]}, {16'd0, exp_wd});
                phy_mem[cap[22:18]] = cap[15:0];
            end
        end
    end

    always @(negedge mdc) begin
        if (ph_op == 2'b10 && ph_rises == 47)
            mdio_i = 1'b0;
        else if (ph_op == 2'b10 && ph_rises >= 48 && ph_rises <= 63)
            mdio_i = phy_mem[ph_reg][63 - ph_rises];
        else
            mdio_i = 1'b1;
    end

    task automatic host_write(logic [7:0] a, logic [31:0] d);
        @(posedge clk); #2;
        host_addr = a; host_wr = 1'b1; host_wdata = d;
        @(posedge clk); #2;
        host_wr = 1'b0; host_addr = OFS;
    endtask

    task automatic wait_done();
        @(posedge clk);
        while (m_busy) @(posedge clk);
        repeat (3) @(posedge clk);
        #2;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        while (cycles < 150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 32; i++) phy_mem[i] = 16'(16'h1000 + i * 16'h0123);
        repeat (5) @(posedge clk);
        #2;
        check("R1 reset word", host_rdata, 32'd0);
        check("R1 reset mdc", {31'd0, mdc}, 32'd0);
        check("R1 reset oe", {31'd0, mdio_oe}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // R3: write with mixed data
        host_write(OFS, 32'h8005_A5C3);
        check("R3 busy flag", host_rdata, 32'h8005_A5C3);
        wait_done();
        check("R3 done flag", host_rdata, 32'h0005_A5C3);

        // R4: read back what was written
        host_write(OFS, 32'h0005_0000);
        check("R4 busy flag", host_rdata, 32'h0005_0000);
        wait_done();
        check("R4 read data", host_rdata, 32'h8005_A5C3);

        // R5: upper address bits and reserved bits set
        host_write(OFS, 32'hFF3F_FFFF);
        check("R5 reserved zero", host_rdata, 32'h803F_FFFF);
        wait_done();
        check("R5 write done", host_rdata, 32'h003F_FFFF);
        host_write(OFS, 32'h001F_0000);
        wait_done();
        check("R5 truncated address read", host_rdata, 32'h801F_FFFF);

        // All-zero data
        host_write(OFS, 32'h8000_0000);
        wait_done();
        check("R3 zero write", host_rdata, 32'h0000_0000);
        host_write(OFS, 32'h0000_0000);
        wait_done();
        check("R4 zero read", host_rdata, 32'h8000_0000);

        // Unwritten register
        host_write(OFS, 32'h000A_0000);
        wait_done();
        check("R4 preset read", host_rdata, {16'h800A, 16'(16'h1000 + 10 * 16'h0123)});

        // R2: another address
        host_write(8'h64, 32'h80AA_1234);
        repeat (4) @(posedge clk);
        #2;
        check("R2 ignored write", host_rdata, 32'h800A_0000 | {16'd0, 16'(16'h1000 + 10 * 16'h0123)});
        check("R2 busy not started", {31'd0, mdc | mdio_oe}, 32'd0);
        host_addr = 8'h64;
        #1;
        check("R2 other read zero", host_rdata, 32'd0);
        host_addr = OFS;

        // R9: command during a read frame
        host_write(OFS, 32'h0005_0000);
        repeat (20) @(posedge clk);
        host_write(OFS, 32'h8007_1111);
        check("R9 ignored while busy", host_rdata, 32'h0005_0000);
        wait_done();
        check("R9 read unaffected", host_rdata, 32'h8005_A5C3);
        check("R9 no write reached phy", {16'd0, phy_mem[7]}, {16'd0, 16'(16'h1000 + 7 * 16'h0123)});

        repeat (5) @(posedge clk);
        finish_run();
    end

endmodule